// File: doc/BRIEF.md
# Montgomery Ladder Instruction Sequencer

This block is the control unit of a binary-field elliptic curve scalar multiplier built around one pipelined field multiplier. It takes a start pulse, a scalar and its bit length. It then steps through three counted phases: a fixed initialization block, the ladder loop and a fixed conversion block. During the ladder loop it issues at most one micro-instruction per clock. Each issue carries a role select. That select tells the datapath which point pair plays the i role and which plays the j role for the current scalar bit. The block also raises per-register write enables when the datapath results land.

The ladder processes the scalar from bit t-2 down to bit 0, and treats bit t-1 as a 1. Each bit issues six instructions in eight clock slots. The slots assume a multiplier latency of four cycles, with the multiplier output register forwarded into the fifth instruction. Whether the first multiply of a bit writes X or Z first depends on whether that bit equals the bit before it. The last two results of a bit are written back while the next bit is already issuing, so bits overlap.

Top module: `ladder_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, phase is 0, issue is 0, instr is 0, wr_en is 0 and done is 0.
- R2: A start sampled while idle begins the phase sequence, counted from the next cycle. Phase 1 (initialization: six states plus one setup cycle) lasts 7 cycles. Phase 2 (ladder) lasts 8·(t-1) cycles. Phase 3 (conversion) lasts 125 cycles. The following cycle shows phase 0 with done high for exactly one cycle. The busy time is therefore 6+1+8·(t-1)+125 cycles.
- R3: Each ladder bit occupies slots 0..7. Slot 0 and slot 1 issue the two leading multiplies. Slots 2, 3, 5 and 6 issue codes 3, 4, 5 and 6. Slots 4 and 7 issue nothing. Instruction codes are 1..6 for the six ladder operations and 0 for no issue. Code 6 always directly follows code 5.
- R4: For bit k, compare it with bit k+1; for k = t-2, compare it with 1. If the two are equal, slot 0 issues code 2 and slot 1 issues code 1. Otherwise slot 0 issues code 1 and slot 1 issues code 2.
- R5: issue is high exactly when instr is nonzero. During the ladder, sel_ij equals the scalar bit being processed: 1 means the first pair takes the i role. sel_ij is 0 outside the ladder.
- R6: Exactly 4 cycles after an issue, wr_en raises the multiply destination. The wr_en bits are: bit0 X of pair 1, bit1 Z of pair 1, bit2 X of pair 2, bit3 Z of pair 2, bit4 T. The destinations are: code 1 Xi, code 2 Zi, code 3 Xj, code 4 Zj, code 5 T, code 6 Xi.
- R7: One cycle after code 3 issues, wr_en raises T. One cycle after code 5 issues, wr_en raises Zi. These writes are ORed with any multiply write in the same cycle.
- R8: A bit length of 0 is treated as 1, and one above 163 is treated as 163. A length of 1 gives an empty ladder. Scalar bits at index t-1 and above have no effect on the trace.
- R9: A start pulse that arrives while the block is busy has no effect on the running trace.
- R10: No instruction issues outside phase 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scalar multiplication (sampled when idle) |
| scalar | input | 163 | Scalar value, captured at start |
| bit_len | input | 8 | Scalar bit length t, captured at start |
| instr | output | 3 | Micro-instruction code, 0 when nothing issues |
| issue | output | 1 | Instruction issue strobe |
| sel_ij | output | 1 | Role select: 1 means pair 1 is i and pair 2 is j |
| wr_en | output | 5 | Register write enables {T, Z2, X2, Z1, X1} |
| phase | output | 2 | 0 idle, 1 init, 2 ladder, 3 conversion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest behaviour to reach is the swap of the leading multiply order at every change between equal and unequal neighbouring bits. This must hold together with write enables that land four cycles later, inside the next bit's issue window or inside the conversion phase. The stimulus uses alternating, run-length-varied and full-length scalars so that both orders and every transition occur, including the first bit, which is compared against an implied 1. Further runs cover a cleared top bit, junk above the length, out-of-range lengths and a start pulse mid-run, to show that the trace ignores them.

// File: rtl/ladder_seq_pkg.sv
package ladder_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_INIT   = 2'd1,
    PH_LADDER = 2'd2,
    PH_CONV   = 2'd3
  } phase_t;

  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_E1   = 3'd1;
  localparam logic [2:0] OP_E2   = 3'd2;
  localparam logic [2:0] OP_E3   = 3'd3;
  localparam logic [2:0] OP_E4   = 3'd4;
  localparam logic [2:0] OP_E5   = 3'd5;
  localparam logic [2:0] OP_E6   = 3'd6;

  localparam int NREG = 5;

  // one-hot register select: is_z picks Z over X, pair_one picks pair 1
  function automatic logic [NREG-1:0] coord_reg(input logic is_z, input logic pair_one);
    logic [NREG-1:0] r;
    r = '0;
    r[(pair_one ? 0 : 2) + (is_z ? 1 : 0)] = 1'b1;
    return r;
  endfunction

  function automatic logic [NREG-1:0] t_reg();
    logic [NREG-1:0] r;
    r = '0;
    r[NREG-1] = 1'b1;
    return r;
  endfunction

  // instruction placed in a slot of one ladder bit
  function automatic logic [2:0] slot_op(input int unsigned slot, input int unsigned e5s,
                                         input logic same);
    if (slot == 0)             return same ? OP_E2 : OP_E1;
    else if (slot == 1)        return same ? OP_E1 : OP_E2;
    else if (slot == 2)        return OP_E3;
    else if (slot == 3)        return OP_E4;
    else if (slot == e5s)      return OP_E5;
    else if (slot == e5s + 1)  return OP_E6;
    return OP_NONE;
  endfunction

  // destination of the multiplier result; sel=1 means pair 1 is i
  function automatic logic [NREG-1:0] mul_dest_f(input logic [2:0] op, input logic sel);
    case (op)
      OP_E1:   return coord_reg(1'b0, sel);
      OP_E2:   return coord_reg(1'b1, sel);
      OP_E3:   return coord_reg(1'b0, ~sel);
      OP_E4:   return coord_reg(1'b1, ~sel);
      OP_E5:   return t_reg();
      OP_E6:   return coord_reg(1'b0, sel);
      default: return '0;
    endcase
  endfunction

  // destination of the single-cycle side result
  function automatic logic [NREG-1:0] imm_dest_f(input logic [2:0] op, input logic sel);
    case (op)
      OP_E3:   return t_reg();
      OP_E5:   return coord_reg(1'b1, sel);
      default: return '0;
    endcase
  endfunction

  function automatic int unsigned clamp_len(input int unsigned raw, input int unsigned nb);
    if (raw < 1)  return 1;
    if (raw > nb) return nb;
    return raw;
  endfunction

endpackage

// File: rtl/lseq_fsm.sv
module lseq_fsm
  import ladder_seq_pkg::*;
#(
  parameter int NB     = 163,
  parameter int TW     = 8,
  parameter int INIT_N = 6,
  parameter int CONV_N = 125,
  parameter int PERIOD = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NB-1:0]             scalar,
  input  logic [TW-1:0]             bit_len,
  output phase_t                    phase,
  output logic [$clog2(PERIOD)-1:0] slot,
  output logic                      cur_bit,
  output logic                      same_bit,
  output logic                      bit_end,
  output logic                      done
);
  localparam int SW = $clog2(PERIOD);
  localparam int CW = $clog2(INIT_N + CONV_N + 1);

  logic [NB-1:0] sc;
  logic [TW-1:0] tlen, k, kp1;
  logic [CW-1:0] cnt;
  logic          top_bit;

  assign kp1      = k + 1'b1;
  assign top_bit  = (k == TW'(tlen - TW'(2)));
  assign cur_bit  = sc[k];
  assign same_bit = (cur_bit == (top_bit ? 1'b1 : sc[kp1]));
  assign bit_end  = (phase == PH_LADDER) && (slot == SW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sc    <= '0;
      tlen  <= '0;
      k     <= '0;
      cnt   <= '0;
      slot  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          sc    <= scalar;
          tlen  <= TW'(clamp_len(int'(bit_len), NB));
          cnt   <= '0;
          phase <= PH_INIT;
        end
        PH_INIT: if (cnt == CW'(INIT_N)) begin
          cnt  <= '0;
          slot <= '0;
          if (tlen >= TW'(2)) begin
            k     <= TW'(tlen - TW'(2));
            phase <= PH_LADDER;
          end else begin
            phase <= PH_CONV;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_LADDER: if (bit_end) begin
          slot <= '0;
          if (k == '0) begin
            cnt   <= '0;
            phase <= PH_CONV;
          end else begin
            k <= k - 1'b1;
          end
        end else begin
          slot <= slot + 1'b1;
        end
        default: if (cnt == CW'(CONV_N - 1)) begin
          cnt   <= '0;
          done  <= 1'b1;
          phase <= PH_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lseq_issue.sv
module lseq_issue
  import ladder_seq_pkg::*;
#(
  parameter int SW  = 3,
  parameter int E5S = 5
) (
  input  logic            in_ladder,
  input  logic [SW-1:0]   slot,
  input  logic            same_bit,
  input  logic            cur_bit,
  output logic [2:0]      instr,
  output logic            issue,
  output logic            sel_ij,
  output logic [NREG-1:0] mul_dest,
  output logic [NREG-1:0] imm_dest
);
  always_comb begin
    instr    = in_ladder ? slot_op(32'(slot), E5S, same_bit) : OP_NONE;
    issue    = (instr != OP_NONE);
    sel_ij   = in_ladder & cur_bit;
    mul_dest = mul_dest_f(instr, sel_ij);
    imm_dest = imm_dest_f(instr, sel_ij);
  end
endmodule

// File: rtl/lseq_wb.sv
module lseq_wb #(
  parameter int LAT = 4,
  parameter int NR  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] mul_dest,
  input  logic [NR-1:0] imm_dest,
  output logic [NR-1:0] wr_en
);
  logic [LAT-1:0][NR-1:0] stage;
  logic [NR-1:0]          imm_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= mul_dest;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[LAT-2:0], mul_dest};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imm_q <= '0;
    else        imm_q <= imm_dest;
  end

  assign wr_en = stage[LAT-1] | imm_q;
endmodule

// File: rtl/ladder_sequencer.sv
module ladder_sequencer
  import ladder_seq_pkg::*;
#(
  parameter int NB      = 163,
  parameter int LAT     = 4,
  parameter int FORWARD = 1,
  parameter int INIT_N  = 6,
  parameter int CONV_N  = 125
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NB-1:0]            scalar,
  input  logic [$clog2(NB+1)-1:0]  bit_len,
  output logic [2:0]               instr,
  output logic                     issue,
  output logic                     sel_ij,
  output logic [NREG-1:0]          wr_en,
  output logic [1:0]               phase,
  output logic                     done
);
  localparam int TW     = $clog2(NB + 1);
  localparam int E5S    = (FORWARD != 0) ? LAT + 1 : LAT + 2;
  localparam int PERIOD = E5S + 3;
  localparam int SW     = $clog2(PERIOD);

  phase_t          ph;
  logic [SW-1:0]   slot;
  logic            cur_bit, same_bit, bit_end;
  logic [NREG-1:0] mul_dest, imm_dest;

  lseq_fsm #(.NB(NB), .TW(TW), .INIT_N(INIT_N), .CONV_N(CONV_N), .PERIOD(PERIOD)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar), .bit_len(bit_len),
    .phase(ph), .slot(slot), .cur_bit(cur_bit), .same_bit(same_bit),
    .bit_end(bit_end), .done(done)
  );

  lseq_issue #(.SW(SW), .E5S(E5S)) i_issue (
    .in_ladder(ph == PH_LADDER), .slot(slot), .same_bit(same_bit), .cur_bit(cur_bit),
    .instr(instr), .issue(issue), .sel_ij(sel_ij),
    .mul_dest(mul_dest), .imm_dest(imm_dest)
  );

  lseq_wb #(.LAT(LAT), .NR(NREG)) i_wb (
    .clk(clk), .rst_n(rst_n), .mul_dest(mul_dest), .imm_dest(imm_dest), .wr_en(wr_en)
  );

  assign phase = ph;
endmodule

// File: rtl/ladder_sequencer_chk.sv
module ladder_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] instr,
  input logic       issue,
  input logic       sel_ij,
  input logic [4:0] wr_en,
  input logic [1:0] phase,
  input logic       done
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (wr_en == 5'd0 && !issue));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == 2'd3 && phase == 2'd0));

  assert_e6_after_e5_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr == 3'd5) |=> (issue && instr == 3'd6));

  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr == 3'd3) |-> $stable(sel_ij));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && start) |=> (phase != 2'd1));

  assert_issue_in_ladder_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (phase == 2'd2));
endmodule

bind ladder_sequencer ladder_sequencer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .issue(issue),
  .sel_ij(sel_ij), .wr_en(wr_en), .phase(phase), .done(done)
);

// File: tb/test_ladder_sequencer.sv
module test_ladder_sequencer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [162:0] scal = '0;
  logic [7:0]   blen = '0;
  logic [2:0]   instr;
  logic         issue, sel_ij, done;
  logic [4:0]   wr_en;
  logic [1:0]   phase;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_we [0:2047];

  always #5 clk = ~clk;

  ladder_sequencer i_ladder_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scal), .bit_len(blen),
    .instr(instr), .issue(issue), .sel_ij(sel_ij), .wr_en(wr_en),
    .phase(phase), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // one-hot for a coordinate: bit0 X1, bit1 Z1, bit2 X2, bit3 Z2, bit4 T
  function automatic logic [4:0] coord(input bit is_z, input bit pair1);
    int idx;
    idx = (pair1 ? 0 : 2) + (is_z ? 1 : 0);
    return 5'(1 << idx);
  endfunction

  function automatic int ref_op(input int slot, input bit same);
    case (slot)
      0: return same ? 2 : 1;
      1: return same ? 1 : 2;
      2: return 3;
      3: return 4;
      5: return 5;
      6: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic run(input logic [162:0] s, input int len, input int mid);
    int eff, total;
    eff = (len < 1) ? 1 : ((len > 163) ? 163 : len);
    total = 132 + 8 * (eff - 1);
    for (int i = 0; i < 2048; i++) exp_we[i] = 5'd0;
    @(negedge clk);
    scal = s; blen = 8'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int o = 0; o <= total; o++) begin
      int ep, eop, esel, slot, k;
      bit same, prev;
      ep = 0; eop = 0; esel = 0;
      if (o < 7) ep = 1;
      else if (o < 7 + 8 * (eff - 1)) begin
        ep = 2;
        slot = (o - 7) % 8;
        k = eff - 2 - (o - 7) / 8;
        prev = (k == eff - 2) ? 1'b1 : s[k + 1];
        same = (s[k] == prev);
        eop = ref_op(slot, same);
        esel = s[k];
      end else if (o < total) ep = 3;
      if (eop != 0) begin
        case (eop)
          1: exp_we[o + 4] |= coord(0, esel[0]);
          2: exp_we[o + 4] |= coord(1, esel[0]);
          3: begin exp_we[o + 4] |= coord(0, !esel[0]); exp_we[o + 1] |= 5'b10000; end
          4: exp_we[o + 4] |= coord(1, !esel[0]);
          5: begin exp_we[o + 4] |= 5'b10000; exp_we[o + 1] |= coord(1, esel[0]); end
          default: exp_we[o + 4] |= coord(0, esel[0]);
        endcase
      end
      chk(phase == 2'(ep), "R2", "phase", int'(phase), ep);
      chk(done == (o == total), "R2", "done", int'(done), int'(o == total));
      if (ep == 2 && ((o - 7) % 8) < 2)
        chk(int'(instr) == eop, "R4", "lead multiply order", int'(instr), eop);
      else
        chk(int'(instr) == eop, "R3 R10", "instr", int'(instr), eop);
      chk(issue == (eop != 0), "R5", "issue", int'(issue), int'(eop != 0));
      if (eop != 0) chk(int'(sel_ij) == esel, "R5", "sel_ij", int'(sel_ij), esel);
      chk(wr_en == exp_we[o], "R6/R7", "wr_en", int'(wr_en), int'(exp_we[o]));
      // R9: a second start while busy, with a different scalar and length
      if (mid > 0 && o == mid) begin
        start = 1'b1; scal = ~s; blen = 8'd3;
      end else start = 1'b0;
      @(negedge clk);
    end
    chk(phase == 2'd0 && !done && wr_en == 5'd0, "R1", "idle after run",
        int'({phase, done, wr_en}), 0);
  endtask

  function automatic logic [162:0] pat(input int n, input int mode);
    logic [162:0] v;
    v = '0;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: v[i] = i[0];
        1: v[i] = ((i * 7) % 5) < 2;
        default: v[i] = ((i / 3) % 2) == 1;
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [162:0] v;
    repeat (3) @(negedge clk);
    // R1: outputs while held in reset
    chk(phase == 2'd0 && !issue && instr == 3'd0 && wr_en == 5'd0 && !done,
        "R1", "reset state", int'({phase, issue, instr, wr_en, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && !issue && wr_en == 5'd0 && !done,
        "R1", "idle state", int'({phase, issue, wr_en, done}), 0);
    run(163'b10, 2, 0);                       // R4 differs from implied top
    run(163'b11, 2, 0);                       // R4 equal to implied top
    v = pat(10, 0); v[9] = 1'b1; v[20] = 1'b1;
    run(v, 10, 0);                            // alternating bits
    v = pat(12, 2); v[11] = 1'b0; v[100] = 1'b1;
    run(v, 12, 40);                           // R8 cleared top bit, R9 busy start
    run(pat(163, 1), 163, 600);               // full length, R9 during ladder
    run(163'h1, 1, 20);                       // R8 empty ladder, R9 during conv
    run(163'h5, 0, 0);                        // R8 length 0 treated as 1
    run(pat(163, 2), 200, 0);                 // R8 length above 163
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule